// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block arbitrates ten interrupt sources for an 8051-class processor core. Each source has an enable bit and a priority bit. These bits sit in four byte-wide registers on a small address, data and write-strobe bus. A global enable bit gates every source. In every cycle the block combines the pending lines with the register contents and the in-service state. It then presents one request line to the core, together with the source index of the winning request.

Arbitration works at two levels. A high-level request always beats a low-level one. Within one level, a fixed polling order picks the winner: lower index wins. The core reports that it accepted the request with a one-cycle acknowledge pulse. It reports the end of a handler with a one-cycle return pulse. The block keeps one in-service flag per level. With these flags it lets a high-level request pre-empt a low-level handler, and it lets nothing pre-empt a high-level handler.

Source indices follow the polling order:

| Index | Source |
|---|---|
| 0 | external line A |
| 1 | serial port B |
| 2 | timer 0 |
| 3 | two-wire bus |
| 4 | external line B |
| 5 | display data channel |
| 6 | timer 1 |
| 7 | USB |
| 8 | serial port A |
| 9 | timer 2 |

Top module: `irqArbiter`

## Requirements
- R1: After reset all four registers read 0x00, irqReq is 0 and irqIdx is 0.
- R2: The registers are mapped as follows: main enable at 0xA8, extra enable at 0xA7, main priority at 0xB8, extra priority at 0xB7. Reads are combinational and return the stored value with reserved bits forced to 0. In the main enable register bit 6 is reserved. In the main priority register bits 7:6 are reserved. In both extra registers bits 7:4 are reserved. Any other address reads 0x00, and a write to it changes nothing.
- R3: Bit 7 of the main enable register is the global enable. While it is 0, irqReq stays 0 whatever else is pending or enabled.
- R4: A source can win only if it is pending and its own enable bit is 1. The bit positions are the same in the enable and priority registers:
  - Main registers: bit 0 is index 0, bit 1 is index 2, bit 2 is index 4, bit 3 is index 6, bit 4 is index 8, bit 5 is index 9.
  - Extra registers: bit 3 is index 5, bit 2 is index 1, bit 1 is index 3, bit 0 is index 7.
- R5: A priority bit of 1 puts the source at the high level. Any eligible high-level source beats every low-level source.
- R6: Within one level the eligible source with the lowest index wins, and its index appears on irqIdx. irqIdx is 0 when irqReq is 0.
- R7: An acknowledge while irqReq is 1 marks the winner's level in service. While only the low level is in service, irqReq is asserted for eligible high-level sources only.
- R8: While the high level is in service, irqReq is 0.
- R9: A return pulse clears the high in-service flag if it is set. Otherwise it clears the low in-service flag.
- R10: A register write takes effect at the clock edge that samples it, and arbitration in the cycle after that edge uses the new value. irqReq and irqIdx follow srcPend in the same cycle, with no register in between.
- R11: An acknowledge while irqReq is 0 changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regWrEn | input | 1 | Write strobe |
| regRdData | output | 8 | Read data for regAddr |
| srcPend | input | 10 | Pending lines, indexed in polling order |
| ackPulse | input | 1 | Core accepted the current request |
| retiPulse | input | 1 | Core finished a handler |
| irqReq | output | 1 | Request to the core |
| irqIdx | output | 4 | Index of the winning source |

## Verification
Arbitration outputs and read data are combinational. The bench checks them shortly after it changes srcPend or regAddr on a falling edge, without waiting for another clock. Register writes and the acknowledge and return pulses are sampled at one rising edge. The bench drives each of them for exactly one cycle. It checks their effect at the falling edge that follows, which is the first point where the new register or flag value can show at the ports.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int NUM_SRC = 10;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int DATA_W  = 8;

  localparam logic [7:0] ADDR_EN_MAIN  = 8'hA8;
  localparam logic [7:0] ADDR_EN_EXTRA = 8'hA7;
  localparam logic [7:0] ADDR_PR_MAIN  = 8'hB8;
  localparam logic [7:0] ADDR_PR_EXTRA = 8'hB7;

  localparam logic [7:0] MASK_EN_MAIN = 8'hBF;
  localparam logic [7:0] MASK_PR_MAIN = 8'h3F;
  localparam logic [7:0] MASK_EXTRA   = 8'h0F;

  typedef struct packed {
    logic wrEnMain;
    logic wrEnExtra;
    logic wrPrMain;
    logic wrPrExtra;
  } regStrobes_t;

  // Spread register bits into polling-order source vector
  function automatic logic [NUM_SRC-1:0] toPollOrder(input logic [7:0] mainReg,
                                                    input logic [7:0] extraReg);
    logic [NUM_SRC-1:0] v;
    v[0] = mainReg[0];
    v[1] = extraReg[2];
    v[2] = mainReg[1];
    v[3] = extraReg[1];
    v[4] = mainReg[2];
    v[5] = extraReg[3];
    v[6] = mainReg[3];
    v[7] = extraReg[0];
    v[8] = mainReg[4];
    v[9] = mainReg[5];
    return v;
  endfunction
endpackage

// File: rtl/irqRegs.sv
module irqRegs
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strobes,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         wrData,
  input  logic [NUM_SRC-1:0] srcPend,
  output logic [7:0]         rdData,
  output logic               globalEn,
  output logic [NUM_SRC-1:0] eligHi,
  output logic [NUM_SRC-1:0] eligLo
);
  logic [7:0] enMain, enExtra, prMain, prExtra;
  logic [NUM_SRC-1:0] enVec, prVec, live;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enMain  <= '0;
      enExtra <= '0;
      prMain  <= '0;
      prExtra <= '0;
    end else begin
      if (strobes.wrEnMain)  enMain  <= wrData & MASK_EN_MAIN;
      if (strobes.wrEnExtra) enExtra <= wrData & MASK_EXTRA;
      if (strobes.wrPrMain)  prMain  <= wrData & MASK_PR_MAIN;
      if (strobes.wrPrExtra) prExtra <= wrData & MASK_EXTRA;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_EN_MAIN:  rdData = enMain;
      ADDR_EN_EXTRA: rdData = enExtra;
      ADDR_PR_MAIN:  rdData = prMain;
      ADDR_PR_EXTRA: rdData = prExtra;
      default:       rdData = '0;
    endcase
  end

  assign globalEn = enMain[7];
  assign enVec    = toPollOrder(enMain, enExtra);
  assign prVec    = toPollOrder(prMain, prExtra);
  assign live     = srcPend & enVec & {NUM_SRC{globalEn}};
  assign eligHi   = live & prVec;
  assign eligLo   = live & ~prVec;

  AST_RSVD_PR_MAIN_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_PR_MAIN) |-> (rdData[7:6] == 2'b00)) else $error("reserved bits"); // R2
  AST_RSVD_EXTRA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_EN_EXTRA) |-> (rdData[7:4] == 4'h0)) else $error("reserved bits"); // R2
  AST_ELIG_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    ((eligHi | eligLo) & ~srcPend) == '0) else $error("unpending eligible"); // R4
endmodule

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         regAddr,
  input  logic               regWrEn,
  input  logic               ackPulse,
  input  logic               retiPulse,
  input  logic               globalEn,
  input  logic [NUM_SRC-1:0] eligHi,
  input  logic [NUM_SRC-1:0] eligLo,
  output regStrobes_t        strobes,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx
);
  logic inHi, inLo, nextHi, nextLo;
  logic hiFound, loFound, winHi;
  logic [IDX_W-1:0] hiIdx, loIdx;

  always_comb begin
    strobes.wrEnMain  = regWrEn && (regAddr == ADDR_EN_MAIN);
    strobes.wrEnExtra = regWrEn && (regAddr == ADDR_EN_EXTRA);
    strobes.wrPrMain  = regWrEn && (regAddr == ADDR_PR_MAIN);
    strobes.wrPrExtra = regWrEn && (regAddr == ADDR_PR_EXTRA);
  end

  // Polling order: lowest index first, scanned downward so low index wins
  always_comb begin
    hiFound = 1'b0;
    loFound = 1'b0;
    hiIdx   = '0;
    loIdx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligHi[i]) begin
        hiFound = 1'b1;
        hiIdx   = IDX_W'(i);
      end
      if (eligLo[i]) begin
        loFound = 1'b1;
        loIdx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    winHi  = 1'b0;
    irqReq = 1'b0;
    irqIdx = '0;
    if (!inHi) begin
      if (hiFound) begin
        winHi  = 1'b1;
        irqReq = 1'b1;
        irqIdx = hiIdx;
      end else if (loFound && !inLo) begin
        irqReq = 1'b1;
        irqIdx = loIdx;
      end
    end
  end

  always_comb begin
    nextHi = inHi;
    nextLo = inLo;
    if (retiPulse) begin
      if (inHi) nextHi = 1'b0;
      else      nextLo = 1'b0;
    end
    if (ackPulse && irqReq) begin
      if (winHi) nextHi = 1'b1;
      else       nextLo = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inHi <= 1'b0;
      inLo <= 1'b0;
    end else begin
      inHi <= nextHi;
      inLo <= nextLo;
    end
  end

  AST_NO_GLOBAL_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqReq) else $error("req with global off"); // R3
  AST_REQ_IS_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (eligHi[irqIdx] || eligLo[irqIdx])) else $error("bad winner"); // R4
  AST_LO_SERVICE_HI_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (inLo && irqReq) |-> eligHi[irqIdx]) else $error("low nested in low"); // R7
  AST_HI_ACK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && irqReq && winHi && !retiPulse) |=> !irqReq) else $error("req during high"); // R8
  AST_RETI_HI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (retiPulse && inHi && !ackPulse) |=> (!inHi && inLo == $past(inLo))) else $error("reti order"); // R9
  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ackPulse && !irqReq && !retiPulse) |=> (inHi == $past(inHi) && inLo == $past(inLo)))
    else $error("idle ack changed state"); // R11
endmodule

// File: rtl/irqArbiter.sv
module irqArbiter
  import irqPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         regAddr,
  input  logic [7:0]         regWrData,
  input  logic               regWrEn,
  output logic [7:0]         regRdData,
  input  logic [NUM_SRC-1:0] srcPend,
  input  logic               ackPulse,
  input  logic               retiPulse,
  output logic               irqReq,
  output logic [IDX_W-1:0]   irqIdx
);
  regStrobes_t strobes;
  logic globalEn;
  logic [NUM_SRC-1:0] eligHi, eligLo;

  irqRegs i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .wrData(regWrData), .srcPend(srcPend), .rdData(regRdData),
    .globalEn(globalEn), .eligHi(eligHi), .eligLo(eligLo)
  );

  irqCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .ackPulse(ackPulse), .retiPulse(retiPulse), .globalEn(globalEn),
    .eligHi(eligHi), .eligLo(eligLo), .strobes(strobes),
    .irqReq(irqReq), .irqIdx(irqIdx)
  );
endmodule

// File: tb/test_irqArbiter.sv
module test_irqArbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regRdData;
  logic [9:0] srcPend = '0;
  logic ackPulse = 1'b0, retiPulse = 1'b0;
  logic irqReq;
  logic [3:0] irqIdx;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  irqArbiter i_irqArbiter (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .srcPend(srcPend),
    .ackPulse(ackPulse), .retiPulse(retiPulse), .irqReq(irqReq), .irqIdx(irqIdx)
  );

  // {enMain, enExtra, prMain, prExtra, pend, expReq, expIdx}
  localparam int NV = 10;
  localparam logic [46:0] VEC [NV] = '{
    {8'h3F, 8'h0F, 8'h00, 8'h00, 10'h3FF, 1'b0, 4'd0},  // R3 global off
    {8'hBF, 8'h0F, 8'h00, 8'h00, 10'h3FF, 1'b1, 4'd0},  // R6
    {8'hBF, 8'h0F, 8'h00, 8'h00, 10'h3FE, 1'b1, 4'd1},  // R6
    {8'hBF, 8'h0F, 8'h00, 8'h00, 10'h200, 1'b1, 4'd9},  // R6
    {8'hBF, 8'h0F, 8'h20, 8'h00, 10'h3FF, 1'b1, 4'd9},  // R5
    {8'hBF, 8'h0F, 8'h20, 8'h08, 10'h3FF, 1'b1, 4'd5},  // R5 R6
    {8'h81, 8'h00, 8'h00, 8'h00, 10'h3FE, 1'b0, 4'd0},  // R4
    {8'h80, 8'h01, 8'h00, 8'h00, 10'h3FF, 1'b1, 4'd7},  // R4
    {8'hA0, 8'h04, 8'h20, 8'h00, 10'h3FF, 1'b1, 4'd9},  // R4 R5
    {8'hBF, 8'h0F, 8'h00, 8'h02, 10'h3F0, 1'b1, 4'd4}   // R5 R6
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkArb(input string tag, input logic eReq, input logic [3:0] eIdx);
    #1;
    check(tag, {3'b0, irqReq, irqIdx}, {3'b0, eReq, eIdx});
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic pulse(input bit isAck);
    @(negedge clk);
    if (isAck) ackPulse = 1'b1; else retiPulse = 1'b1;
    @(negedge clk);
    ackPulse = 1'b0; retiPulse = 1'b0;
  endtask

  task automatic setPend(input logic [9:0] p);
    srcPend = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readCheck("R1 enMain", 8'hA8, 8'h00);
    readCheck("R1 enExtra", 8'hA7, 8'h00);
    readCheck("R1 prMain", 8'hB8, 8'h00);
    readCheck("R1 prExtra", 8'hB7, 8'h00);
    setPend(10'h3FF);
    checkArb("R1 no request", 1'b0, 4'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      writeReg(8'hA8, VEC[v][46:39]);
      writeReg(8'hA7, VEC[v][38:31]);
      writeReg(8'hB8, VEC[v][30:23]);
      writeReg(8'hB7, VEC[v][22:15]);
      setPend(VEC[v][14:5]);
      checkArb($sformatf("R4 R5 R6 vector %0d", v), VEC[v][4], VEC[v][3:0]);
    end

    // R2 reserved bits and unmapped address
    writeReg(8'hA8, 8'hFF);
    readCheck("R2 enMain rsvd", 8'hA8, 8'hBF);
    writeReg(8'hB8, 8'hFF);
    readCheck("R2 prMain rsvd", 8'hB8, 8'h3F);
    writeReg(8'hB7, 8'hFF);
    readCheck("R2 prExtra rsvd", 8'hB7, 8'h0F);
    writeReg(8'hA9, 8'h00);
    readCheck("R2 unmapped read", 8'hA9, 8'h00);
    readCheck("R2 unmapped write", 8'hA8, 8'hBF);

    // R10: write immediately changes arbitration
    writeReg(8'hB8, 8'h00);
    writeReg(8'hB7, 8'h00);
    writeReg(8'hA7, 8'h0F);
    setPend(10'h010);
    writeReg(8'hA8, 8'h3F);
    checkArb("R10 global cleared", 1'b0, 4'd0);
    @(negedge clk);
    regAddr = 8'hA8; regWrData = 8'hBF; regWrEn = 1'b1;
    #1;
    check("R10 before edge", {7'b0, irqReq}, 8'h00);
    @(negedge clk);
    regWrEn = 1'b0;
    checkArb("R10 after edge", 1'b1, 4'd4);
    setPend(10'h004);
    checkArb("R10 pend same cycle", 1'b1, 4'd2);

    // Nesting: index 0 high, others low
    writeReg(8'hB8, 8'h01);
    setPend(10'h000);
    pulse(1'b1);
    setPend(10'h010);
    checkArb("R11 idle ack ignored", 1'b1, 4'd4);
    pulse(1'b1);
    checkArb("R7 low in service blocks low", 1'b0, 4'd0);
    setPend(10'h011);
    checkArb("R7 high pre-empts low", 1'b1, 4'd0);
    pulse(1'b1);
    setPend(10'h3FF);
    checkArb("R8 high in service", 1'b0, 4'd0);
    pulse(1'b0);
    setPend(10'h010);
    checkArb("R9 high cleared low kept", 1'b0, 4'd0);
    setPend(10'h011);
    checkArb("R9 high allowed again", 1'b1, 4'd0);
    pulse(1'b0);
    setPend(10'h010);
    checkArb("R9 low cleared", 1'b1, 4'd4);

    // R1 reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readCheck("R1 reset clears enMain", 8'hA8, 8'h00);
    checkArb("R1 reset clears request", 1'b0, 4'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule